// File: doc/BRIEF.md
# Segmented Offset Step Unit

This block moves an 8-bit offset by a signed 8-bit step and keeps an 8-bit segment byte in step with it. The segment forms the high byte and the offset the low byte of a 16-bit byte address. A datapath uses it to advance an instruction pointer through a code segment by one 16-bit word, or to move a stack pointer up or down inside a stack segment.

When the carry control is high, a step that carries the offset past its top value raises the segment by one. A step that borrows below zero lowers the segment by one. When the control is low, the segment passes through untouched and only the offset wraps. Both results are registered on the rising clock edge. A step of zero writes both inputs back unchanged, so a caller can issue a write every cycle without moving the pointer.

Top module: `seg_step_unit`

## Requirements
- R1: One clock edge after the inputs are applied, `ofs_o` equals (`ofs_i` + `step_i`) mod 256, with `step_i` read as two's complement. This holds whatever the value of `carry_en_i`.
- R2: With `carry_en_i` low, `seg_o` equals the `seg_i` sampled at the same edge, whether or not the offset wraps.
- R3: With `carry_en_i` high and a non-negative step (bit 7 of `step_i` clear) whose unsigned sum with `ofs_i` exceeds 0xFF, `seg_o` becomes `seg_i` + 1 mod 256 (0xFF goes to 0x00).
- R4: With `carry_en_i` high and a negative step (bit 7 set) whose magnitude exceeds `ofs_i`, `seg_o` becomes `seg_i` - 1 mod 256 (0x00 goes to 0xFF).
- R5: With `carry_en_i` high and an offset sum that stays within 0x00..0xFF, `seg_o` equals `seg_i`.
- R6: A step of 0x00 reproduces both `ofs_i` and `seg_i` on the outputs, for either value of `carry_en_i`.
- R7: A high `rst_i` at a rising edge clears both outputs to 0x00 and takes priority over every other input.
- R8: Outputs change only at a rising edge. Input changes between edges leave `ofs_o` and `seg_o` unchanged until the next edge.
- R9: With `carry_en_i` high, a step of 0x02 raises the 16-bit address {`seg_o`,`ofs_o`} by 2 mod 65536, and a step of 0xFE lowers it by 2. This includes steps across segment boundaries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| carry_en_i | input | 1 | Lets an offset carry or borrow adjust the segment |
| ofs_i | input | 8 | Current offset (low address byte) |
| seg_i | input | 8 | Current segment (high address byte) |
| step_i | input | 8 | Signed step added to the offset |
| ofs_o | output | 8 | Registered new offset |
| seg_o | output | 8 | Registered new segment |

## Verification
The hardest case is a borrow at the extreme. The offset sits at 0x00, the step is 0x80 (the largest negative step) and the segment is also 0x00, so the segment must wrap to 0xFF. The opposite corner also needs a deliberate vector: offset 0xFF with step 0x7F and segment 0xFF. The stimulus places these vectors directly and repeats each with the carry control low. It then walks the 16-bit address across a segment boundary in both directions, and adds a pseudo-random sweep that mixes positive, negative and zero steps.

// File: rtl/seg_step_pkg.sv
package seg_step_pkg;

    // Direction in which the segment byte must move after an offset step
    typedef enum logic [1:0] {
        SEG_HOLD = 2'd0,
        SEG_INC  = 2'd1,
        SEG_DEC  = 2'd2
    } seg_move_e;

endpackage

// File: rtl/ofs_adder.sv
module ofs_adder
    import seg_step_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  logic [OFS_W-1:0] ofs_i,
    input  logic [OFS_W-1:0] step_i,
    output logic [OFS_W-1:0] sum_o,
    output seg_move_e        move_o
);

    localparam int EXT_W = OFS_W + 2;

    logic [EXT_W-1:0] ofs_ext;
    logic [EXT_W-1:0] step_ext;
    logic [EXT_W-1:0] total;

    // Offset is unsigned, step is signed; two guard bits separate carry from borrow
    assign ofs_ext  = {2'b00, ofs_i};
    assign step_ext = {{2{step_i[OFS_W-1]}}, step_i};
    assign total    = ofs_ext + step_ext;
    assign sum_o    = total[OFS_W-1:0];

    always_comb begin
        if (total[EXT_W-1])
            move_o = SEG_DEC;
        else if (total[OFS_W])
            move_o = SEG_INC;
        else
            move_o = SEG_HOLD;
    end

endmodule

// File: rtl/seg_adjust.sv
module seg_adjust
    import seg_step_pkg::*;
#(
    parameter int SEG_W = 8
) (
    input  logic [SEG_W-1:0] seg_i,
    input  seg_move_e        move_i,
    input  logic             carry_en_i,
    output logic [SEG_W-1:0] seg_o
);

    always_comb begin
        seg_o = seg_i;
        if (carry_en_i) begin
            unique case (move_i)
                SEG_INC: seg_o = seg_i + SEG_W'(1);
                SEG_DEC: seg_o = seg_i - SEG_W'(1);
                default: seg_o = seg_i;
            endcase
        end
    end

endmodule

// File: rtl/seg_step_unit.sv
module seg_step_unit
    import seg_step_pkg::*;
#(
    parameter int OFS_W = 8,
    parameter int SEG_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             carry_en_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic [SEG_W-1:0] seg_i,
    input  logic [OFS_W-1:0] step_i,
    output logic [OFS_W-1:0] ofs_o,
    output logic [SEG_W-1:0] seg_o
);

    typedef struct packed {
        logic [SEG_W-1:0] seg;
        logic [OFS_W-1:0] ofs;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    logic [OFS_W-1:0] sum_w;
    seg_move_e        move_w;
    logic [SEG_W-1:0] seg_w;

    ofs_adder #(.OFS_W(OFS_W)) u_add (
        .ofs_i  (ofs_i),
        .step_i (step_i),
        .sum_o  (sum_w),
        .move_o (move_w)
    );

    seg_adjust #(.SEG_W(SEG_W)) u_seg (
        .seg_i      (seg_i),
        .move_i     (move_w),
        .carry_en_i (carry_en_i),
        .seg_o      (seg_w)
    );

    always_comb begin
        ptr_d     = ptr_q;
        ptr_d.ofs = sum_w;
        ptr_d.seg = seg_w;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)
            ptr_q <= '0;
        else
            ptr_q <= ptr_d;
    end

    assign ofs_o = ptr_q.ofs;
    assign seg_o = ptr_q.seg;

endmodule

// File: rtl/seg_step_chk.sv
module seg_step_chk #(
    parameter int OFS_W = 8,
    parameter int SEG_W = 8
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             carry_en_i,
    input logic [OFS_W-1:0] ofs_i,
    input logic [SEG_W-1:0] seg_i,
    input logic [OFS_W-1:0] step_i,
    input logic [OFS_W-1:0] ofs_o,
    input logic [SEG_W-1:0] seg_o
);

    logic [OFS_W-1:0] step_mag;
    logic [OFS_W:0]   pos_sum;

    assign step_mag = -step_i;
    assign pos_sum  = {1'b0, ofs_i} + {1'b0, step_i};

    // R1
    ofs_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ofs_o == OFS_W'($past(ofs_i) + $past(step_i)));

    // R2
    seg_pass_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !carry_en_i |=> seg_o == $past(seg_i));

    // R3
    seg_inc_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (carry_en_i && !step_i[OFS_W-1] && pos_sum[OFS_W]) |=>
        seg_o == SEG_W'($past(seg_i) + SEG_W'(1)));

    // R4
    seg_dec_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (carry_en_i && step_i[OFS_W-1] && (ofs_i < step_mag)) |=>
        seg_o == SEG_W'($past(seg_i) - SEG_W'(1)));

    // R6
    zero_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i == '0) |=> (ofs_o == $past(ofs_i)) && (seg_o == $past(seg_i)));

    // R7
    reset_clear_chk: assert property (@(posedge clk_i)
        rst_i |=> (ofs_o == '0) && (seg_o == '0));

endmodule

bind seg_step_unit seg_step_chk #(.OFS_W(OFS_W), .SEG_W(SEG_W)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .carry_en_i (carry_en_i),
    .ofs_i      (ofs_i),
    .seg_i      (seg_i),
    .step_i     (step_i),
    .ofs_o      (ofs_o),
    .seg_o      (seg_o)
);

// File: tb/seg_step_unit_tb.sv
`timescale 1ns/1ps
module seg_step_unit_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       ce;
    logic [7:0] ofs, seg, step;
    logic [7:0] ofs_q, seg_q;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [7:0] ofs;
        logic [7:0] seg;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    seg_step_unit u_dut (
        .clk_i      (clk),
        .rst_i      (rst),
        .carry_en_i (ce),
        .ofs_i      (ofs),
        .seg_i      (seg),
        .step_i     (step),
        .ofs_o      (ofs_q),
        .seg_o      (seg_q)
    );

    function automatic exp_t model(input logic [7:0] o, input logic [7:0] s,
                                   input logic [7:0] st, input logic c,
                                   input logic r, input string tag);
        exp_t e;
        int   total;
        total = int'(o) + int'($signed(st));
        e.tag = tag;
        if (r) begin
            e.ofs = 8'h00;
            e.seg = 8'h00;
        end else begin
            e.ofs = total[7:0];
            e.seg = s;
            if (c && total > 255) e.seg = s + 8'd1;
            if (c && total < 0)   e.seg = s - 8'd1;
        end
        return e;
    endfunction

    task automatic check(input string tag, input logic [7:0] ao, input logic [7:0] as,
                         input logic [7:0] eo, input logic [7:0] es);
        n_chk++;
        if (ao !== eo || as !== es) begin
            n_bad++;
            $display("FAIL %s: got seg=%h ofs=%h, expected seg=%h ofs=%h", tag, as, ao, es, eo);
        end
    endtask

    task automatic drive(input logic [7:0] o, input logic [7:0] s, input logic [7:0] st,
                         input logic c, input logic r, input string tag);
        @(negedge clk);
        ofs = o; seg = s; step = st; ce = c; rst = r;
        sb.push_back(model(o, s, st, c, r, tag));
    endtask

    // Monitor: compares one result per edge, 1 ns after it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, ofs_q, seg_q, e.ofs, e.seg);
            end
        end
    end

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #20000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got hung run, expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] addr;
        logic [7:0]  lfsr;
        rst = 1'b1; ce = 1'b0; ofs = 8'h00; seg = 8'h00; step = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        check("R7 reset state", ofs_q, seg_q, 8'h00, 8'h00);

        drive(8'h5A, 8'h33, 8'h00, 1'b1, 1'b0, "R6 zero step ce=1");
        drive(8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, "R6 zero step ce=0");
        drive(8'h10, 8'h40, 8'h02, 1'b1, 1'b0, "R1 R5 no crossing");
        drive(8'h90, 8'h40, 8'hF0, 1'b1, 1'b0, "R5 negative no borrow");
        drive(8'hFE, 8'h40, 8'h02, 1'b1, 1'b0, "R3 carry into segment");
        drive(8'hFF, 8'hFF, 8'h7F, 1'b1, 1'b0, "R3 segment wraps to 00");
        drive(8'hFE, 8'h40, 8'h02, 1'b0, 1'b0, "R2 carry suppressed");
        drive(8'h01, 8'h40, 8'hFE, 1'b0, 1'b0, "R2 borrow suppressed");
        drive(8'h01, 8'h40, 8'hFE, 1'b1, 1'b0, "R4 borrow from segment");
        drive(8'h00, 8'h00, 8'h80, 1'b1, 1'b0, "R4 segment wraps to FF");
        drive(8'h33, 8'h77, 8'h55, 1'b1, 1'b1, "R7 reset priority");

        // R8: disturb inputs between edges, outputs must hold
        drive(8'h20, 8'h12, 8'h04, 1'b1, 1'b0, "R8 setup");
        @(posedge clk);
        #1.5;
        ofs = 8'hFF; seg = 8'hAA; step = 8'h7F; ce = 1'b1;
        #0.4;
        check("R8 hold between edges", ofs_q, seg_q, 8'h24, 8'h12);

        // R9: walk the 16-bit address across a segment boundary, both ways
        for (int i = 0; i < 6; i++) begin
            addr = 16'h01FA + 16'(2 * i);
            drive(addr[7:0], addr[15:8], 8'h02, 1'b1, 1'b0, "R9 forward");
        end
        for (int i = 0; i < 6; i++) begin
            addr = 16'h0206 - 16'(2 * i);
            drive(addr[7:0], addr[15:8], 8'hFE, 1'b1, 1'b0, "R9 backward");
        end
        drive(8'hFE, 8'hFF, 8'h02, 1'b1, 1'b0, "R9 address wraps to 0000");
        drive(8'h00, 8'h00, 8'hFE, 1'b1, 1'b0, "R9 address wraps to FFFE");

        // R1 sweep with mixed steps and carry control
        lfsr = 8'hA5;
        for (int i = 0; i < 48; i++) begin
            logic [7:0] a, b, c;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]}; a = lfsr;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]}; b = lfsr;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]}; c = lfsr;
            drive(a, b, (i % 7 == 0) ? 8'h00 : c, c[0], 1'b0, "R1 sweep");
        end

        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule